// File: doc/BRIEF.md
# Cyclic Extension and Edge Window Stage

This stage sits at the transmit end of a multicarrier modulator. It accepts core blocks of `N_CORE` complex samples, one sample per handshake, and emits each block as an extended block: a copy of the block's tail as a cyclic prefix, the full block, and a copy of its head as a cyclic suffix. The first few and last few samples of every extended block are shaped by a symmetric taper. Only the rising half of the taper is held in memory. The falling half is read from the same entries in reverse order.

A frame opens with a precomputed preamble of `N_PRE` samples. Software writes the preamble into its own memory during configuration. The preamble is extended and tapered with its own lengths and its own half-window. When the first sample of an incoming block is flagged as the start of a frame, the stage first takes in that whole block. It then plays out the extended preamble, followed by the extended data block. Configuration inputs must stay unchanged while a block is being taken in or played out.

Samples are packed as `{I, Q}`, with I in the upper half. Each component is a signed `DW`-bit value. Taper coefficients are unsigned Q1.15 numbers in which `0x8000` stands for 1.0.

Top module: `cpw_inserter`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: For a data block d[0..N-1], with `cfg_ncp`=P and `cfg_ncs`=S, the output is d[N-P..N-1], then d[0..N-1], then d[0..S-1], in that order, for P+N+S samples.
- R3: With `cfg_ncp`=0 the extended block starts directly with d[0]. With `cfg_ncs`=0 it ends directly with d[N-1].
- R4: With `cfg_nw`=W and extended length L, sample k<W is scaled by window entry k. Sample L-1-k (k<W) is scaled by window entry k. Samples in between pass unchanged. Data entries sit at window addresses 0..W_MAX-1. Scaling of each of I and Q is floor((x*c)/32768), where c is unsigned Q1.15 and 0x8000 means 1.0.
- R5: With `cfg_nw`=0 no output sample of a data block is scaled.
- R6: A block whose first sample carries `in_first`=1 is preceded by the extended preamble. That preamble is built from the preamble memory using `cfg_pcp`, `cfg_pcs` and `cfg_pw`, and its window entries sit at addresses W_MAX..2*W_MAX-1. A block with `in_first`=0 gets no preamble.
- R7: `in_ready` stays 0 from the acceptance of a block's last input sample until the last sample of its extended block has been loaded into the output register. No samples are emitted other than those of R2, R4 and R6.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_ncp | input | LW | Data cyclic prefix length |
| cfg_ncs | input | LW | Data cyclic suffix length |
| cfg_nw | input | LW | Data taper half length |
| cfg_pcp | input | LW | Preamble cyclic prefix length |
| cfg_pcs | input | LW | Preamble cyclic suffix length |
| cfg_pw | input | LW | Preamble taper half length |
| pre_we | input | 1 | Preamble memory write enable |
| pre_addr | input | AW_P | Preamble memory write address |
| pre_wdata | input | 2*DW | Preamble sample {I,Q} |
| win_we | input | 1 | Window memory write enable |
| win_addr | input | AW_W | Window memory write address |
| win_wdata | input | DW | Window coefficient, unsigned Q1.15 |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Stage can take an input sample |
| in_first | input | 1 | Marks a frame start on a block's first sample |
| in_data | input | 2*DW | Input sample {I,Q} |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Sink takes the output sample |
| out_data | output | 2*DW | Output sample {I,Q} |

## Verification
The assertions assume three things about the configuration. First, prefix and suffix lengths do not exceed the block length. Second, twice the taper length fits inside the extended block. Third, no configuration input or memory changes while a block is in flight. The bench writes both memories and changes lengths only after its expected-sample queue has drained, and it picks every length inside these bounds, including the maximum prefix and suffix. Random stalls on `out_ready` exercise the hold rule, while the reference queue checks every accepted output.

// File: rtl/cpw_pkg.sv
// Shared types for the cyclic extension and window stage.
package cpw_pkg;
    // Phase of the stage: taking in a block, playing out preamble, playing out data.
    typedef enum logic [1:0] {
        ST_FILL = 2'd0,
        ST_PRE  = 2'd1,
        ST_DATA = 2'd2
    } phase_e;
endpackage

// File: rtl/cpw_ram.sv
// Simple single-write, asynchronous-read storage array.
// Assumes the reader tolerates a combinational read path.
module cpw_ram #(
    parameter int DEPTH = 16,
    parameter int W     = 32,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    // Write one entry per cycle.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/cpw_seq.sv
// Maps an output position inside an extended block to a source index and a
// window entry. Assumes cp, cs <= nblk and 2*nw <= cp+nblk+cs.
module cpw_seq #(
    parameter int LW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic [LW-1:0] pos,
    input  logic [LW-1:0] nblk,
    input  logic [LW-1:0] cp,
    input  logic [LW-1:0] cs,
    input  logic [LW-1:0] nw,
    output logic [LW-1:0] src,
    output logic          use_win,
    output logic [LW-1:0] win_k,
    output logic          last
);
    logic [LW-1:0] total;

    // Decode the prefix / body / suffix region and the taper region.
    always_comb begin
        total = cp + nblk + cs;
        if (pos < cp)             src = nblk - cp + pos;
        else if (pos < cp + nblk) src = pos - cp;
        else                      src = pos - cp - nblk;
        use_win = 1'b0;
        win_k   = '0;
        if (pos < nw) begin
            use_win = 1'b1;
            win_k   = pos;
        end else if (pos >= total - nw) begin
            use_win = 1'b1;
            win_k   = total - 1'b1 - pos;
        end
        last = (pos == total - 1'b1);
    end

    // R2: every read lands inside the stored block and inside the extended length
    a_r2_src_in_block: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (src < nblk) && (pos < total));
    // R4: a taper index never reaches past the configured half length
    a_r4_win_in_half: assert property (@(posedge clk) disable iff (!rst_n)
        (active && use_win) |-> (win_k < nw));
endmodule

// File: rtl/cpw_scale.sv
// Multiplies signed I and Q by an unsigned Q1.15 coefficient with floor
// rounding; passes samples unchanged when disabled.
module cpw_scale #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] coef,
    input  logic          en,
    input  logic [DW-1:0] in_i,
    input  logic [DW-1:0] in_q,
    output logic [DW-1:0] out_i,
    output logic [DW-1:0] out_q
);
    localparam logic [DW-1:0] ONE = DW'(1) << (DW - 1);
    logic signed [2*DW:0] pi, pq;

    // Full-precision products, then an arithmetic shift by DW-1.
    always_comb begin
        pi    = (2*DW+1)'($signed(in_i)) * (2*DW+1)'($signed({1'b0, coef}));
        pq    = (2*DW+1)'($signed(in_q)) * (2*DW+1)'($signed({1'b0, coef}));
        out_i = en ? pi[DW-1 +: DW] : in_i;
        out_q = en ? pq[DW-1 +: DW] : in_q;
    end

    // R4: a unity coefficient leaves the sample untouched
    always_comb begin
        if (en && coef == ONE) begin
            a_r4_unity: assert (out_i == in_i && out_q == in_q);
        end
    end
endmodule

// File: rtl/cpw_inserter.sv
// Top of the cyclic extension and edge window stage. Buffers one core block,
// then plays out an optional extended preamble and the extended block.
// Assumes configuration and memories are stable while a block is in flight.
module cpw_inserter #(
    parameter int DW     = 16,
    parameter int N_CORE = 16,
    parameter int N_PRE  = 8,
    parameter int W_MAX  = 8,
    localparam int NMAX  = (N_CORE > N_PRE) ? N_CORE : N_PRE,
    localparam int LW    = $clog2(3*NMAX + 1),
    localparam int SW    = 2*DW,
    localparam int AW_C  = (N_CORE > 1) ? $clog2(N_CORE) : 1,
    localparam int AW_P  = (N_PRE > 1) ? $clog2(N_PRE) : 1,
    localparam int AW_W  = $clog2(2*W_MAX)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LW-1:0]   cfg_ncp,
    input  logic [LW-1:0]   cfg_ncs,
    input  logic [LW-1:0]   cfg_nw,
    input  logic [LW-1:0]   cfg_pcp,
    input  logic [LW-1:0]   cfg_pcs,
    input  logic [LW-1:0]   cfg_pw,
    input  logic            pre_we,
    input  logic [AW_P-1:0] pre_addr,
    input  logic [SW-1:0]   pre_wdata,
    input  logic            win_we,
    input  logic [AW_W-1:0] win_addr,
    input  logic [DW-1:0]   win_wdata,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic            in_first,
    input  logic [SW-1:0]   in_data,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [SW-1:0]   out_data
);
    import cpw_pkg::*;

    localparam logic [LW-1:0]   NC_L = LW'(N_CORE);
    localparam logic [LW-1:0]   NP_L = LW'(N_PRE);
    localparam logic [AW_C-1:0] WR_LAST = AW_C'(N_CORE - 1);

    phase_e          st_q;
    logic [AW_C-1:0] wr_q;
    logic            pend_q;
    logic [LW-1:0]   pos_q;

    logic            is_pre, step, in_hs;
    logic [LW-1:0]   cp, cs, nw, nblk, src, win_k;
    logic            use_win, last;
    logic [SW-1:0]   buf_rd, pre_rd, smp;
    logic [DW-1:0]   coef, sc_i, sc_q;
    logic [AW_W-1:0] win_rd_addr;

    assign in_ready = (st_q == ST_FILL);
    assign in_hs    = in_valid && in_ready;
    assign is_pre   = (st_q == ST_PRE);
    assign step     = (st_q != ST_FILL) && (!out_valid || out_ready);

    // Select the length set of the block being played out.
    always_comb begin
        cp   = is_pre ? cfg_pcp : cfg_ncp;
        cs   = is_pre ? cfg_pcs : cfg_ncs;
        nw   = is_pre ? cfg_pw  : cfg_nw;
        nblk = is_pre ? NP_L    : NC_L;
    end

    cpw_ram #(.DEPTH(N_CORE), .W(SW)) u_blk (
        .clk(clk), .we(in_hs), .waddr(wr_q), .wdata(in_data),
        .raddr(src[AW_C-1:0]), .rdata(buf_rd));

    cpw_ram #(.DEPTH(N_PRE), .W(SW)) u_pre (
        .clk(clk), .we(pre_we), .waddr(pre_addr), .wdata(pre_wdata),
        .raddr(src[AW_P-1:0]), .rdata(pre_rd));

    assign win_rd_addr = AW_W'(win_k) + (is_pre ? AW_W'(W_MAX) : AW_W'(0));

    cpw_ram #(.DEPTH(2*W_MAX), .W(DW)) u_win (
        .clk(clk), .we(win_we), .waddr(win_addr), .wdata(win_wdata),
        .raddr(win_rd_addr), .rdata(coef));

    cpw_seq #(.LW(LW)) u_seq (
        .clk(clk), .rst_n(rst_n), .active(st_q != ST_FILL),
        .pos(pos_q), .nblk(nblk), .cp(cp), .cs(cs), .nw(nw),
        .src(src), .use_win(use_win), .win_k(win_k), .last(last));

    assign smp = is_pre ? pre_rd : buf_rd;

    cpw_scale #(.DW(DW)) u_scale (
        .coef(coef), .en(use_win), .in_i(smp[SW-1:DW]), .in_q(smp[DW-1:0]),
        .out_i(sc_i), .out_q(sc_q));

    // Phase control: take in a block, then walk the extended positions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_FILL;
            wr_q   <= '0;
            pend_q <= 1'b0;
            pos_q  <= '0;
        end else begin
            case (st_q)
                ST_FILL: if (in_hs) begin
                    if (wr_q == '0) pend_q <= in_first;
                    if (wr_q == WR_LAST) begin
                        wr_q  <= '0;
                        pos_q <= '0;
                        st_q  <= ((wr_q == '0) ? in_first : pend_q) ? ST_PRE : ST_DATA;
                    end else begin
                        wr_q <= wr_q + AW_C'(1);
                    end
                end
                default: if (step) begin
                    pos_q <= last ? '0 : pos_q + LW'(1);
                    if (last) st_q <= is_pre ? ST_DATA : ST_FILL;
                end
            endcase
        end
    end

    // Output register with valid/ready hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (step) begin
            out_valid <= 1'b1;
            out_data  <= {sc_i, sc_q};
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R8: a stalled output keeps its value
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    // R6: the preamble is always followed by the data block
    a_r6_pre_then_data: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PRE && step && last) |=> (st_q == ST_DATA));
    // R7: no input is taken right after a block has been fully accepted
    a_r7_closed_after_block: assert property (@(posedge clk) disable iff (!rst_n)
        (in_hs && wr_q == WR_LAST) |=> !in_ready);
    // R7: the stage reopens once the data block has been played out
    a_r7_reopen: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DATA && step && last) |=> in_ready);
endmodule

// File: tb/cpw_inserter_bench.sv
module cpw_inserter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16, N_CORE = 16, N_PRE = 8, W_MAX = 8;
    localparam int LW = $clog2(3*N_CORE + 1);
    localparam int SW = 2*DW;
    localparam int AW_P = $clog2(N_PRE), AW_W = $clog2(2*W_MAX);

    logic clk = 0, rst_n = 0;
    logic [LW-1:0] cfg_ncp = 0, cfg_ncs = 0, cfg_nw = 0, cfg_pcp = 0, cfg_pcs = 0, cfg_pw = 0;
    logic pre_we = 0, win_we = 0, in_valid = 0, in_first = 0, out_ready = 1;
    logic [AW_P-1:0] pre_addr = 0;
    logic [AW_W-1:0] win_addr = 0;
    logic [SW-1:0] pre_wdata = 0, in_data = 0;
    logic [DW-1:0] win_wdata = 0;
    logic in_ready, out_valid;
    logic [SW-1:0] out_data;

    int total = 0, bad = 0;
    bit mon_on = 0, bp_on = 0, done = 0;
    string tag = "R1";
    logic [SW-1:0] q[$];
    logic [SW-1:0] blk [N_CORE];
    logic [SW-1:0] pre_m [N_PRE];
    logic [DW-1:0] win_m [2*W_MAX];

    always #(CLK_PERIOD/2) clk = ~clk;

    cpw_inserter #(.DW(DW), .N_CORE(N_CORE), .N_PRE(N_PRE), .W_MAX(W_MAX)) u_cpw_inserter (
        .clk(clk), .rst_n(rst_n), .cfg_ncp(cfg_ncp), .cfg_ncs(cfg_ncs), .cfg_nw(cfg_nw),
        .cfg_pcp(cfg_pcp), .cfg_pcs(cfg_pcs), .cfg_pw(cfg_pw),
        .pre_we(pre_we), .pre_addr(pre_addr), .pre_wdata(pre_wdata),
        .win_we(win_we), .win_addr(win_addr), .win_wdata(win_wdata),
        .in_valid(in_valid), .in_ready(in_ready), .in_first(in_first), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

    function automatic logic [DW-1:0] scl(logic [DW-1:0] x, logic [DW-1:0] c);
        longint p;
        p = longint'($signed(x)) * longint'(c);
        p = p >>> (DW - 1);
        return p[DW-1:0];
    endfunction

    task automatic check(bit ok, string what, logic [SW-1:0] act, logic [SW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Build the expected extended block and append it to the queue (R2, R3, R4, R5, R6).
    task automatic push_ext(bit ip, int cp, int cs, int nw);
        int n = ip ? N_PRE : N_CORE;
        int len = cp + n + cs;
        int base = ip ? W_MAX : 0;
        for (int p = 0; p < len; p++) begin
            int s;
            logic [SW-1:0] x;
            if (p < cp) s = n - cp + p;
            else if (p < cp + n) s = p - cp;
            else s = p - cp - n;
            x = ip ? pre_m[s] : blk[s];
            if (p < nw) x = {scl(x[SW-1:DW], win_m[base+p]), scl(x[DW-1:0], win_m[base+p])};
            else if (p >= len - nw)
                x = {scl(x[SW-1:DW], win_m[base+len-1-p]), scl(x[DW-1:0], win_m[base+len-1-p])};
            q.push_back(x);
        end
    endtask

    task automatic send_block(bit first);
        for (int i = 0; i < N_CORE; i++) blk[i] = $urandom;
        for (int i = 0; i < N_CORE; i++) begin
            in_valid = 1;
            in_data  = blk[i];
            in_first = first && (i == 0);
            do @(negedge clk); while (!in_ready);
            @(posedge clk); #1;
        end
        in_valid = 0;
        in_first = 0;
        if (first) push_ext(1, int'(cfg_pcp), int'(cfg_pcs), int'(cfg_pw));
        push_ext(0, int'(cfg_ncp), int'(cfg_ncs), int'(cfg_nw));
    endtask

    task automatic wait_idle();
        while (q.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
        #1;
    endtask

    // Reference comparison every clock, away from the active edge.
    logic          was_stall = 0;
    logic [SW-1:0] stall_data = 0;
    always @(negedge clk) begin
        if (mon_on) begin
            if (was_stall)
                check(out_valid && out_data == stall_data, "R8 hold", out_data, stall_data);
            if (q.size() > 1)
                check(!in_ready, "R7 in_ready during emission", {31'd0, in_ready}, '0);
            if (out_valid && out_ready) begin
                if (q.size() == 0) check(0, "R7 extra output", out_data, '0);
                else begin
                    logic [SW-1:0] e;
                    e = q.pop_front();
                    check(out_data == e, "sample", out_data, e);
                end
            end
            was_stall  = out_valid && !out_ready;
            stall_data = out_data;
        end
    end

    // Sink stall pattern.
    always @(posedge clk) begin
        #1;
        out_ready = bp_on ? (($urandom % 3) != 0) : 1'b1;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog R7 actual=hang expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        tag = "R1";
        check(!out_valid, "reset out_valid", {31'd0, out_valid}, '0);
        check(in_ready, "reset in_ready", {31'd0, in_ready}, 1);
        rst_n = 1;
        // Load preamble and window memories.
        for (int i = 0; i < N_PRE; i++) begin
            pre_m[i] = $urandom;
            pre_we = 1; pre_addr = AW_P'(i); pre_wdata = pre_m[i];
            @(posedge clk); #1;
        end
        pre_we = 0;
        for (int i = 0; i < 2*W_MAX; i++) begin
            win_m[i] = (i == 3) ? 16'h8000 : DW'($urandom % 32769);
            win_we = 1; win_addr = AW_W'(i); win_wdata = win_m[i];
            @(posedge clk); #1;
        end
        win_we = 0;
        mon_on = 1;

        tag = "R2"; cfg_ncp = 4; cfg_ncs = 2; cfg_nw = 0;
        send_block(0); wait_idle();
        tag = "R5"; send_block(0); wait_idle();
        tag = "R3"; cfg_ncp = 0; cfg_ncs = 0;
        send_block(0); wait_idle();
        tag = "R3"; cfg_ncp = 0; cfg_ncs = 5;
        send_block(0); wait_idle();
        tag = "R4"; cfg_ncp = 4; cfg_ncs = 4; cfg_nw = 5;
        send_block(0); wait_idle();
        tag = "R6"; cfg_pcp = 2; cfg_pcs = 1; cfg_pw = 3;
        send_block(1); send_block(0); wait_idle();
        tag = "R8"; bp_on = 1; cfg_ncp = 16; cfg_ncs = 16; cfg_nw = 8;
        send_block(1); send_block(0); send_block(1); wait_idle();
        tag = "R2"; bp_on = 0; cfg_ncp = 1; cfg_ncs = 1; cfg_nw = 1;
        send_block(0); wait_idle();
        tag = "R7";
        check(q.size() == 0 && in_ready, "drained and open", {31'd0, in_ready}, 1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule